// File: doc/BRIEF.md
# ADC Serial Result Frame Generator

This block is the device side of a serial ADC read port. It holds the latest conversion result and shifts it out as a 24-bit frame. The frame carries a live end-of-conversion flag, a sign flag and a clamped 17-bit code. While it shifts the result out, it collects a 16-bit configuration word from the controller. That word is passed on to the next conversion only if it carries a valid preamble. A synchronous `convDone` pulse, from a counter or any other model, stands in for the converter itself.

The chip select, serial clock and serial data lines are asynchronous. Each passes through a two-stage synchronizer, and its edges are detected in the system clock domain. The serial clock therefore has to stay at each level for at least four system clocks. The output is given as a data bit plus an output enable, so that a pad can build the tri-state driver.

Top module: `adc_frame_gen`

## Requirements
- R1: While `csN` is high, `sdoOe` and `sdo` are 0 and serial clock edges have no effect. A frame begins at bit 23 whenever `csN` falls.
- R2: After reset a conversion is in progress. With `csN` low and no falling SCK edge yet in the frame, `sdo` shows the EOC flag: 1 while converting, 0 once the conversion is done.
- R3: A `convDone` pulse during a conversion latches `convValue` and ends the conversion. A `convDone` pulse while no conversion is running is ignored, and the held result stays as it was.
- R4: While a conversion is running, SCK edges are ignored and `sdo` stays 1.
- R5: Frame layout: bit 23 is the EOC flag, bit 22 is 0, bit 21 is the sign flag, bits 20..4 are the 17-bit code with bit 20 as its MSB, and bits 3..0 are 0. The k-th falling SCK edge (k = 1..23) drives frame bit 23-k on `sdo`.
- R6: For an input v with -65536 <= v <= 65535, the sign flag is 1 exactly when v >= 0, and bits 20..4 are the 17-bit two's complement of v.
- R7: An input above 65535 is coded as 65536 (sign 1, MSB 1). An input below -65536 is coded as -65537 (sign 0, MSB 0, bits 19..4 all 1).
- R8: On the 24th falling SCK edge `sdo` goes to 1 and a new conversion starts. That high level is the EOC flag of the next frame.
- R9: If `csN` rises before the 24th falling edge, the frame is abandoned and no conversion starts. The next frame repeats the same result from bit 23.
- R10: Within a frame, `sdi` is sampled on the first 16 rising SCK edges, MSB first. On the 24th falling edge the word is copied to `activeCfg`, but only if its bits 15..14 are `10` and bit 13 is 1. Otherwise `activeCfg` keeps its value, which is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low chip select, asynchronous |
| sck | input | 1 | Serial clock from the controller, asynchronous |
| sdi | input | 1 | Serial configuration data in |
| convDone | input | 1 | One-cycle pulse that ends the conversion in progress |
| convValue | input | 20 | Signed conversion value captured on `convDone` |
| sdo | output | 1 | Serial frame data out |
| sdoOe | output | 1 | Output enable for the `sdo` pad driver |
| activeCfg | output | 16 | Configuration applied to the conversion now running |

## Verification
The frame is read back bit by bit for small positive and negative values, for both in-range extremes (65535 and -65536) and for inputs beyond each end of the range. Together these separate the sign and MSB pairs of the four range regions and show the clamp codes. Configuration words with a good preamble, a bad preamble and a cleared enable bit show which ones commit. A second `convDone` pulse after a conversion has finished shows that the held result is kept. A frame cut off after ten bits, followed by a full read, shows that abandoning a frame neither restarts conversion nor loses the result.

// File: rtl/adc_frame_pkg.sv
package adc_frame_pkg;

  // Per-cycle strobes from control to datapath
  typedef struct packed {
    logic eoc;         // conversion in progress
    logic csActive;    // synchronized chip select asserted
    logic loadResult;  // capture a new conversion value
    logic cfgShift;    // shift one configuration bit in
    logic frameEnd;    // last falling edge of a frame
    logic sdiBit;      // synchronized serial input
  } frameStrb_t;

endpackage

// File: rtl/adc_frame_ctrl.sv
module adc_frame_ctrl
  import adc_frame_pkg::*;
#(
  parameter int FRAME_BITS  = 24,
  parameter int CFG_BITS    = 16,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(FRAME_BITS),
  localparam int RCNT_W     = $clog2(CFG_BITS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csN,
  input  logic             sck,
  input  logic             sdi,
  input  logic             convDone,
  output frameStrb_t       strb,
  output logic [CNT_W-1:0] fallCnt
);

  logic [SYNC_STAGES-1:0] csPipe, sckPipe, sdiPipe;
  logic                   sckPrev;
  logic                   converting;
  logic [RCNT_W-1:0]      riseCnt;

  logic csActive, sckNow, riseEdge, fallEdge, shiftFall, frameEnd, cfgShift, loadResult;

  always_comb begin
    csActive   = !csPipe[SYNC_STAGES-1];
    sckNow     = sckPipe[SYNC_STAGES-1];
    riseEdge   = sckNow && !sckPrev;
    fallEdge   = !sckNow && sckPrev;
    shiftFall  = csActive && !converting && fallEdge;
    frameEnd   = shiftFall && (fallCnt == CNT_W'(FRAME_BITS - 1));
    cfgShift   = csActive && !converting && riseEdge && (riseCnt < RCNT_W'(CFG_BITS));
    loadResult = converting && convDone;

    strb.eoc        = converting;
    strb.csActive   = csActive;
    strb.loadResult = loadResult;
    strb.cfgShift   = cfgShift;
    strb.frameEnd   = frameEnd;
    strb.sdiBit     = sdiPipe[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPipe     <= '1;
      sckPipe    <= '0;
      sdiPipe    <= '0;
      sckPrev    <= 1'b0;
      converting <= 1'b1;
      fallCnt    <= '0;
      riseCnt    <= '0;
    end else begin
      csPipe  <= {csPipe[SYNC_STAGES-2:0], csN};
      sckPipe <= {sckPipe[SYNC_STAGES-2:0], sck};
      sdiPipe <= {sdiPipe[SYNC_STAGES-2:0], sdi};
      sckPrev <= sckNow;

      if (loadResult)    converting <= 1'b0;
      else if (frameEnd) converting <= 1'b1;

      if (!csActive)      fallCnt <= '0;
      else if (frameEnd)  fallCnt <= '0;
      else if (shiftFall) fallCnt <= fallCnt + 1'b1;

      if (!csActive || frameEnd) riseCnt <= '0;
      else if (cfgShift)         riseCnt <= riseCnt + 1'b1;
    end
  end

endmodule

// File: rtl/adc_frame_dp.sv
module adc_frame_dp
  import adc_frame_pkg::*;
#(
  parameter int DATA_BITS  = 16,
  parameter int CFG_BITS   = 16,
  localparam int IN_W       = DATA_BITS + 4,
  localparam int FRAME_BITS = DATA_BITS + 8,
  localparam int CNT_W      = $clog2(FRAME_BITS),
  localparam int RES_W      = DATA_BITS + 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  frameStrb_t             strb,
  input  logic [CNT_W-1:0]       fallCnt,
  input  logic signed [IN_W-1:0] convValue,
  output logic                   sdo,
  output logic                   sdoOe,
  output logic [CFG_BITS-1:0]    activeCfg
);

  localparam logic signed [IN_W-1:0] POS_LIM = IN_W'(1) <<< DATA_BITS;
  localparam logic signed [IN_W-1:0] NEG_LIM = -POS_LIM - IN_W'(1);

  logic signed [IN_W-1:0]  clamped;
  logic [RES_W-1:0]        resultReg;
  logic [CFG_BITS-1:0]     cfgReg;
  logic [FRAME_BITS-1:0]   frameVec;
  logic                    cfgOk;

  always_comb begin
    if (convValue > POS_LIM)      clamped = POS_LIM;
    else if (convValue < NEG_LIM) clamped = NEG_LIM;
    else                          clamped = convValue;
  end

  always_comb begin
    frameVec = {2'b00, resultReg, 4'b0000};
    cfgOk    = (cfgReg[CFG_BITS-1 -: 3] == 3'b101);
    sdoOe    = strb.csActive;
    if (!strb.csActive)     sdo = 1'b0;
    else if (fallCnt == '0) sdo = strb.eoc;
    else                    sdo = frameVec[CNT_W'(FRAME_BITS - 1) - fallCnt];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultReg <= '0;
      cfgReg    <= '0;
      activeCfg <= '0;
    end else begin
      if (strb.loadResult)
        resultReg <= {!clamped[IN_W-1], clamped[DATA_BITS:0]};
      if (strb.cfgShift)
        cfgReg <= {cfgReg[CFG_BITS-2:0], strb.sdiBit};
      if (strb.frameEnd && cfgOk)
        activeCfg <= cfgReg;
    end
  end

endmodule

// File: rtl/adc_frame_gen.sv
module adc_frame_gen
  import adc_frame_pkg::*;
#(
  parameter int DATA_BITS   = 16,
  parameter int CFG_BITS    = 16,
  parameter int SYNC_STAGES = 2,
  localparam int IN_W        = DATA_BITS + 4,
  localparam int FRAME_BITS  = DATA_BITS + 8,
  localparam int CNT_W       = $clog2(FRAME_BITS)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   csN,
  input  logic                   sck,
  input  logic                   sdi,
  input  logic                   convDone,
  input  logic signed [IN_W-1:0] convValue,
  output logic                   sdo,
  output logic                   sdoOe,
  output logic [CFG_BITS-1:0]    activeCfg
);

  frameStrb_t       strb;
  logic [CNT_W-1:0] fallCnt;

  adc_frame_ctrl #(
    .FRAME_BITS(FRAME_BITS), .CFG_BITS(CFG_BITS), .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .sdi(sdi),
    .convDone(convDone), .strb(strb), .fallCnt(fallCnt)
  );

  adc_frame_dp #(
    .DATA_BITS(DATA_BITS), .CFG_BITS(CFG_BITS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .fallCnt(fallCnt),
    .convValue(convValue), .sdo(sdo), .sdoOe(sdoOe), .activeCfg(activeCfg)
  );

endmodule

// File: rtl/adc_frame_gen_chk.sv
module adc_frame_gen_chk #(
  parameter int CNT_W    = 5,
  parameter int CFG_BITS = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                csN,
  input logic                convDone,
  input logic                sdo,
  input logic                sdoOe,
  input logic [CFG_BITS-1:0] activeCfg,
  input logic                eoc,
  input logic                frameEnd,
  input logic [CNT_W-1:0]    fallCnt
);

  // R1
  cs_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csN && $past(csN) && $past(csN, 2) && $past(csN, 3)) |-> (!sdoOe && !sdo));

  // R2
  eoc_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sdoOe && eoc) |-> sdo);

  // R3
  conv_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (eoc && convDone) |=> !eoc);

  // R4
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    eoc |-> (fallCnt == '0));

  // R8
  restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameEnd |=> (eoc && fallCnt == '0));

  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !frameEnd |=> $stable(activeCfg));

endmodule

bind adc_frame_gen adc_frame_gen_chk #(.CNT_W(CNT_W), .CFG_BITS(CFG_BITS)) u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .convDone(convDone),
  .sdo(sdo), .sdoOe(sdoOe), .activeCfg(activeCfg),
  .eoc(strb.eoc), .frameEnd(strb.frameEnd), .fallCnt(fallCnt)
);

// File: tb/adc_frame_gen_tb.sv
module adc_frame_gen_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, sck = 1'b0, sdi = 1'b0, convDone = 1'b0;
  logic signed [19:0] convValue = '0;
  logic sdo, sdoOe;
  logic [15:0] activeCfg;

  int checks = 0, failures = 0;
  bit finished = 0;

  // reference model state
  bit          mConv = 1;
  int          mVal = 0;
  logic [15:0] mCfg = '0;

  always #4 clk = ~clk;

  adc_frame_gen u_dut (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .sdi(sdi),
    .convDone(convDone), .convValue(convValue),
    .sdo(sdo), .sdoOe(sdoOe), .activeCfg(activeCfg)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (8) @(negedge clk);
  endtask

  function automatic logic [23:0] expFrame(int v);
    int c;
    logic [16:0] b;
    c = (v > 65536) ? 65536 : ((v < -65537) ? -65537 : v);
    b = c[16:0];
    return {2'b00, (c >= 0), b, 4'b0000};
  endfunction

  task automatic convPulse(int v);
    @(negedge clk);
    convValue = 20'(v);
    convDone  = 1'b1;
    @(negedge clk);
    convDone  = 1'b0;
    if (mConv) begin
      mConv = 0;
      mVal  = v;
    end
  endtask

  task automatic readFrame(int nFalls, logic [15:0] cfg, string tag);
    logic [23:0] fr;
    fr = expFrame(mVal);
    csN = 1'b0;
    settle();
    check("R2 eoc before shifting", {sdoOe, sdo}, {1'b1, mConv});
    for (int i = 1; i <= nFalls; i++) begin
      sdi = (i <= 16) ? cfg[16-i] : 1'b0;
      sck = 1'b1;
      settle();
      sck = 1'b0;
      settle();
      if (i < 24) check({tag, " frame bit"}, sdo, fr[23-i]);
      else        check("R8 sdo high after last edge", sdo, 1'b1);
    end
    csN = 1'b1;
    settle();
    check("R1 released output", {sdoOe, sdo}, 2'b00);
    if (nFalls == 24) begin
      mConv = 1;
      if (cfg[15:13] == 3'b101) mCfg = cfg;
    end
    check("R10 active configuration", activeCfg, mCfg);
  endtask

  task automatic busyProbe();
    csN = 1'b0;
    settle();
    check("R2 eoc high while converting", {sdoOe, sdo}, 2'b11);
    for (int i = 0; i < 3; i++) begin
      sck = 1'b1; settle();
      sck = 1'b0; settle();
      check("R4 sck ignored while converting", sdo, 1'b1);
    end
    csN = 1'b1;
    settle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    settle();
    check("R1 oe low at reset", {sdoOe, sdo}, 2'b00);
    check("R10 reset configuration", activeCfg, 16'h0000);

    busyProbe();                              // R2, R4

    convPulse(1234);
    readFrame(24, 16'hB5A3, "R6");           // R5, R6, R8, R10 valid
    convPulse(-1);
    convPulse(-300);                         // R3: ignored, result stays -1
    readFrame(24, 16'h4000, "R3");           // R10 bad preamble
    convPulse(65535);
    readFrame(24, 16'h8FFF, "R6");           // R10 enable bit clear
    convPulse(-65536);
    readFrame(24, 16'hA001, "R6");
    convPulse(70000);
    readFrame(24, 16'hBFFF, "R7");           // overrange clamp
    convPulse(-80000);
    readFrame(24, 16'hA0F0, "R7");           // underrange clamp

    // R9: abandoned frame keeps result, no restart
    convPulse(4660);
    readFrame(10, 16'hBEEF, "R9");
    for (int i = 0; i < 3; i++) begin       // R1: sck with CS high
      sck = 1'b1; settle();
      sck = 1'b0; settle();
      check("R1 idle while deselected", {sdoOe, sdo}, 2'b00);
    end
    readFrame(24, 16'hA5A5, "R9");
    busyProbe();

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule